// File: doc/BRIEF.md
# Serial Transceiver Host Control Front End

This block is the processor-side control front end of a programmable serial transceiver. It decodes an 8-bit host bus made of an active-low chip select, active-low read and write strobes and a control/data select line. Control writes land in one of two registers that share a single address. A sequencing state picks the register. The first control write after any reset fills the mode register. Every later control write is a command, until a command asks for an internal reset.

The command register drives the transmitter enable, the receiver enable and the active-low terminal-ready modem output. The mode register goes out unchanged to the serial engines. A control-side read returns a status word built from the engines' ready and empty flags and from the data-set-ready modem input. Data-side accesses pass a byte to the transmitter with a one-cycle load strobe, or return the receiver's byte with a one-cycle take strobe. An external reset is accepted only when it is held long enough.

Top module: `usart_ctrl_front`

## Requirements
- R1: A write strobe with cd=1 updates the control registers only. A write with cd=0 drives `tx_byte` to the written value and pulses `tx_load` for one cycle, and it leaves the mode and command registers unchanged.
- R2: A read with cd=1 returns the status word on `dout`. A read with cd=0 returns `rx_byte` and pulses `rx_take` for one cycle.
- R3: The first control write after any reset is stored as the mode word and appears on `mode_word`. Each later control write is taken as a command.
- R4: Command bit 0 sets `tx_en` and command bit 2 sets `rx_en`.
- R5: When command bit 1 is set, `dtr_n` is driven low. When it is clear, `dtr_n` is high.
- R6: A command with bit 6 set clears the command register, so `tx_en`=0, `rx_en`=0 and `dtr_n`=1, and makes the next control write a mode word.
- R7: When `rst` is held high for RST_MIN (default 6) consecutive clocks, the block goes idle: `tx_en`=0, `rx_en`=0, `dtr_n`=1, `mode_word`=0, and the block waits for a mode word.
- R8: A `rst` pulse shorter than RST_MIN clocks has no effect on any register or on the sequencing state.
- R9: The status word holds transmit-ready in bit 0, `rx_ready` in bit 1, `tx_shift_empty` in bit 2 and the inverse of `dsr_n` in bit 7. Bits 3 to 6 read 0.
- R10: Transmit-ready, on status bit 0 and on the `txrdy` pin, is high only when `tx_buf_empty` is high and `tx_en` is set.
- R11: The write sequence 0x00, 0x00, 0x00, 0x40 to the control address leaves the block waiting for a mode word, whichever state it started in.
- R12: A write strobe held low for several clocks counts as exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, active high, filtered for minimum width |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| din | input | DW | Host write data |
| dout | output | DW | Host read data (registered, 0 when not reading) |
| tx_buf_empty | input | 1 | Transmit holding buffer is empty |
| tx_shift_empty | input | 1 | Transmit shifter is empty |
| rx_ready | input | 1 | Received character available |
| rx_byte | input | DW | Received character |
| dsr_n | input | 1 | Data-set-ready modem input, active low |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| dtr_n | output | 1 | Terminal-ready modem output, active low |
| txrdy | output | 1 | Transmit-ready |
| mode_word | output | DW | Stored mode word |
| tx_byte | output | DW | Character for the transmitter |
| tx_load | output | 1 | One-cycle load strobe for `tx_byte` |
| rx_take | output | 1 | One-cycle strobe for a character read |

## Verification
The bench builds the block with its defaults, DW=8 and RST_MIN=6. With these values a 5-clock reset pulse is the longest one that must be ignored and a 6-clock pulse is the shortest one that must be accepted, so both sides of the reset-width boundary are tested exactly. The 8-bit width puts the status layout and the command bit positions 0, 1, 2 and 6 on a real byte, and the recovery sequence is tested from both sequencing states.

// File: rtl/usart_ctrl_pkg.sv
package usart_ctrl_pkg;
  // Command word bit positions (decoded by the control register)
  localparam int CMD_TXEN  = 0;
  localparam int CMD_DTR   = 1;
  localparam int CMD_RXEN  = 2;
  localparam int CMD_IRST  = 6;

  // Status word bit positions
  localparam int ST_TXRDY  = 0;
  localparam int ST_RXRDY  = 1;
  localparam int ST_TXEMP  = 2;
  localparam int ST_DSR    = 7;

  typedef enum logic {
    SEQ_MODE = 1'b0,
    SEQ_CMD  = 1'b1
  } seq_t;
endpackage

// File: rtl/ucf_rst_filter.sv
module ucf_rst_filter #(
  parameter int RST_MIN = 6
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_acc
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_MIN);
  localparam logic [CW-1:0] TRIP  = CW'(RST_MIN - 1);

  logic [CW-1:0] run_cnt = '0;

  always_ff @(posedge clk) begin
    if (!rst_in)
      run_cnt <= '0;
    else if (run_cnt != LIMIT)
      run_cnt <= run_cnt + 1'b1;
  end

  assign rst_acc = rst_in && (run_cnt >= TRIP);

  // R8: the first high cycle of a pulse never counts as accepted
  p_short_rst_ignored_r8: assert property (@(posedge clk)
    (RST_MIN > 1 && rst_in && !$past(rst_in)) |-> !rst_acc);
endmodule

// File: rtl/ucf_bus_decode.sv
module ucf_bus_decode (
  input  logic clk,
  input  logic rst_acc,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic cd,
  output logic ctrl_wr,
  output logic data_wr,
  output logic data_rd,
  output logic rd_level
);
  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q;

  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n;
  assign rd_level = rd_act;

  always_ff @(posedge clk) begin
    if (rst_acc) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
    end
  end

  assign ctrl_wr = wr_act && !wr_act_q && cd;
  assign data_wr = wr_act && !wr_act_q && !cd;
  assign data_rd = rd_act && !rd_act_q && !cd;

  // R12: a held strobe yields a single write pulse
  p_single_wr_pulse_r12: assert property (@(posedge clk) disable iff (rst_acc)
    (ctrl_wr || data_wr) |=> !(ctrl_wr || data_wr));
endmodule

// File: rtl/ucf_ctrl_regs.sv
module ucf_ctrl_regs
  import usart_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_acc,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cmd_q,
  output logic          want_mode
);
  seq_t seq_q;

  always_ff @(posedge clk) begin
    if (rst_acc) begin
      seq_q  <= SEQ_MODE;
      mode_q <= '0;
      cmd_q  <= '0;
    end else if (ctrl_wr) begin
      if (seq_q == SEQ_MODE) begin
        mode_q <= wdata;
        seq_q  <= SEQ_CMD;
      end else if (wdata[CMD_IRST]) begin
        cmd_q  <= '0;
        seq_q  <= SEQ_MODE;
      end else begin
        cmd_q  <= wdata;
      end
    end
  end

  assign want_mode = (seq_q == SEQ_MODE);

  // R3: a control write taken as mode moves sequencing to command
  p_mode_then_cmd_r3: assert property (@(posedge clk) disable iff (rst_acc)
    (ctrl_wr && want_mode) |=> (!want_mode && mode_q == $past(wdata)));
  // R6: internal reset command returns to mode expectation, disabled
  p_irst_cmd_r6: assert property (@(posedge clk) disable iff (rst_acc)
    (ctrl_wr && !want_mode && wdata[CMD_IRST]) |=> (want_mode && cmd_q == '0));
  // R7: accepted reset leaves command cleared and mode awaited
  p_reset_idle_r7: assert property (@(posedge clk)
    rst_acc |=> (want_mode && cmd_q == '0 && mode_q == '0));
endmodule

// File: rtl/usart_ctrl_front.sv
module usart_ctrl_front
  import usart_ctrl_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RST_MIN = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          tx_buf_empty,
  input  logic          tx_shift_empty,
  input  logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  input  logic          dsr_n,
  output logic          tx_en,
  output logic          rx_en,
  output logic          dtr_n,
  output logic          txrdy,
  output logic [DW-1:0] mode_word,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          rx_take
);
  logic          rst_acc;
  logic          ctrl_wr, data_wr, data_rd, rd_level;
  logic [DW-1:0] mode_q, cmd_q;
  logic          want_mode;
  logic [DW-1:0] status_w;
  logic          txrdy_q, tx_load_q, rx_take_q;
  logic [DW-1:0] dout_q, tx_byte_q;

  ucf_rst_filter #(.RST_MIN(RST_MIN)) u_rst (
    .clk(clk), .rst_in(rst), .rst_acc(rst_acc)
  );

  ucf_bus_decode u_dec (
    .clk(clk), .rst_acc(rst_acc), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd(cd), .ctrl_wr(ctrl_wr), .data_wr(data_wr), .data_rd(data_rd),
    .rd_level(rd_level)
  );

  ucf_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_acc(rst_acc), .ctrl_wr(ctrl_wr), .wdata(din),
    .mode_q(mode_q), .cmd_q(cmd_q), .want_mode(want_mode)
  );

  always_comb begin
    status_w           = '0;
    status_w[ST_TXRDY] = txrdy_q;
    status_w[ST_RXRDY] = rx_ready;
    status_w[ST_TXEMP] = tx_shift_empty;
    status_w[ST_DSR]   = !dsr_n;
  end

  always_ff @(posedge clk) begin
    if (rst_acc) begin
      txrdy_q   <= 1'b0;
      tx_load_q <= 1'b0;
      rx_take_q <= 1'b0;
      dout_q    <= '0;
      tx_byte_q <= '0;
    end else begin
      txrdy_q   <= tx_buf_empty && cmd_q[CMD_TXEN];
      tx_load_q <= data_wr;
      rx_take_q <= data_rd;
      if (data_wr)
        tx_byte_q <= din;
      if (rd_level)
        dout_q <= cd ? status_w : rx_byte;
      else
        dout_q <= '0;
    end
  end

  assign tx_en     = cmd_q[CMD_TXEN];
  assign rx_en     = cmd_q[CMD_RXEN];
  assign dtr_n     = !cmd_q[CMD_DTR];
  assign txrdy     = txrdy_q;
  assign mode_word = mode_q;
  assign tx_byte   = tx_byte_q;
  assign tx_load   = tx_load_q;
  assign rx_take   = rx_take_q;
  assign dout      = dout_q;

  // R10: transmit-ready never rises while transmit is disabled
  p_txrdy_gated_r10: assert property (@(posedge clk) disable iff (rst_acc)
    !tx_en |=> !txrdy);
  // R1: a data write never touches the control registers
  p_data_wr_isolated_r1: assert property (@(posedge clk) disable iff (rst_acc)
    data_wr |=> ($stable(mode_word) && $stable(tx_en) && $stable(rx_en) && $stable(dtr_n)));
  // R5: terminal-ready follows the command bit, active low
  p_dtr_follow_r5: assert property (@(posedge clk) disable iff (rst_acc)
    (ctrl_wr && !want_mode && !din[CMD_IRST]) |=> (dtr_n == !$past(din[CMD_DTR])));
  // R7: accepted reset disables transmitter and receiver
  p_reset_disables_r7: assert property (@(posedge clk)
    rst_acc |=> (!tx_en && !rx_en && dtr_n));
endmodule

// File: tb/usart_ctrl_front_tb_top.sv
module usart_ctrl_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic tx_buf_empty = 1'b0, tx_shift_empty = 1'b0, rx_ready = 1'b0, dsr_n = 1'b1;
  logic [DW-1:0] rx_byte = '0;
  logic tx_en, rx_en, dtr_n, txrdy, tx_load, rx_take;
  logic [DW-1:0] mode_word, tx_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_ctrl_front #(.DW(DW), .RST_MIN(6)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(din), .dout(dout), .tx_buf_empty(tx_buf_empty),
    .tx_shift_empty(tx_shift_empty), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .dsr_n(dsr_n), .tx_en(tx_en), .rx_en(rx_en), .dtr_n(dtr_n), .txrdy(txrdy),
    .mode_word(mode_word), .tx_byte(tx_byte), .tx_load(tx_load), .rx_take(rx_take)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_pulse(input int n);
    @(negedge clk); rst = 1'b1;
    idle(n);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic bus_write(input logic sel, input logic [DW-1:0] v, input int hold);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd = sel; din = v;
    idle(hold);
    cs_n = 1'b1; wr_n = 1'b1;
    idle(2);
  endtask

  task automatic bus_read(input logic sel, output logic [DW-1:0] v, output logic took);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; cd = sel;
    @(negedge clk); v = dout; took = rx_take;
    cs_n = 1'b1; rd_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset_state;
    chk("R7 tx_en after reset", tx_en, 0);
    chk("R7 rx_en after reset", rx_en, 0);
    chk("R7 dtr_n after reset", dtr_n, 1);
    chk("R7 mode_word after reset", mode_word, 0);
    chk("R10 txrdy after reset", txrdy, 0);
  endtask

  task automatic t_mode_and_cmd;
    bus_write(1'b1, 8'h4E, 1);
    chk("R3 first control write is mode", mode_word, 8'h4E);
    chk("R3 mode write not a command", tx_en, 0);
    bus_write(1'b1, 8'h05, 1);
    chk("R4 tx_en from bit0", tx_en, 1);
    chk("R4 rx_en from bit2", rx_en, 1);
    chk("R5 dtr_n high with bit1 clear", dtr_n, 1);
    chk("R3 mode kept after command", mode_word, 8'h4E);
    bus_write(1'b1, 8'h02, 1);
    chk("R5 dtr_n low with bit1 set", dtr_n, 0);
    chk("R4 tx_en cleared", tx_en, 0);
    chk("R4 rx_en cleared", rx_en, 0);
  endtask

  task automatic t_data_path;
    logic [DW-1:0] v; logic took;
    bus_write(1'b1, 8'h07, 1);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd = 1'b0; din = 8'hA5;
    @(negedge clk);
    chk("R1 tx_load pulse", tx_load, 1);
    chk("R1 tx_byte value", tx_byte, 8'hA5);
    @(negedge clk);
    chk("R1 tx_load one cycle", tx_load, 0);
    cs_n = 1'b1; wr_n = 1'b1; idle(2);
    chk("R1 command untouched by data write", {tx_en, rx_en, dtr_n}, 3'b110);
    chk("R1 mode untouched by data write", mode_word, 8'h4E);
    rx_byte = 8'h3C;
    bus_read(1'b0, v, took);
    chk("R2 data read returns rx_byte", v, 8'h3C);
    chk("R2 rx_take pulse", took, 1);
    idle(1);
    chk("R2 rx_take one cycle", rx_take, 0);
  endtask

  task automatic t_status;
    logic [DW-1:0] v; logic took;
    tx_buf_empty = 1'b1; rx_ready = 1'b1; tx_shift_empty = 1'b0; dsr_n = 1'b0;
    idle(3);
    bus_read(1'b1, v, took);
    chk("R9 status pattern A", v, 8'h83);
    chk("R2 status read no rx_take", took, 0);
    chk("R10 txrdy pin enabled+empty", txrdy, 1);
    rx_ready = 1'b0; tx_shift_empty = 1'b1; dsr_n = 1'b1; tx_buf_empty = 1'b0;
    idle(3);
    bus_read(1'b1, v, took);
    chk("R9 status pattern B", v, 8'h04);
    chk("R10 txrdy low buffer full", txrdy, 0);
    tx_buf_empty = 1'b1;
    bus_write(1'b1, 8'h04, 1);
    idle(2);
    bus_read(1'b1, v, took);
    chk("R10 txrdy forced low tx disabled", v[0], 0);
    chk("R10 txrdy pin low tx disabled", txrdy, 0);
  endtask

  task automatic t_internal_reset;
    bus_write(1'b1, 8'h47, 1);
    chk("R6 tx_en off after internal reset", tx_en, 0);
    chk("R6 dtr_n high after internal reset", dtr_n, 1);
    bus_write(1'b1, 8'h5D, 1);
    chk("R6 next control write is mode", mode_word, 8'h5D);
    chk("R6 mode write not a command", tx_en, 0);
  endtask

  task automatic t_recovery_from_cmd;
    bus_write(1'b1, 8'h27, 1);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h40, 1);
    bus_write(1'b1, 8'h6A, 1);
    chk("R11 recovery from command state", mode_word, 8'h6A);
  endtask

  task automatic t_recovery_from_mode;
    reset_pulse(8);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h00, 1);
    bus_write(1'b1, 8'h40, 1);
    bus_write(1'b1, 8'h99, 1);
    chk("R11 recovery from mode state", mode_word, 8'h99);
    chk("R11 enables idle after recovery", {tx_en, rx_en}, 2'b00);
  endtask

  task automatic t_reset_width;
    bus_write(1'b1, 8'h07, 1);
    reset_pulse(5);
    chk("R8 5-cycle reset ignored tx_en", tx_en, 1);
    chk("R8 5-cycle reset ignored mode", mode_word, 8'h99);
    bus_write(1'b1, 8'h01, 1);
    chk("R8 still in command state", tx_en, 1);
    chk("R8 mode unchanged", mode_word, 8'h99);
    reset_pulse(6);
    chk("R7 6-cycle reset disables tx", tx_en, 0);
    chk("R7 6-cycle reset clears mode", mode_word, 0);
    bus_write(1'b1, 8'h12, 1);
    chk("R7 waits for mode after reset", mode_word, 8'h12);
  endtask

  task automatic t_held_strobe;
    reset_pulse(7);
    bus_write(1'b1, 8'h11, 4);
    chk("R12 held strobe single write mode", mode_word, 8'h11);
    chk("R12 held strobe not repeated as command", tx_en, 0);
  endtask

  initial begin
    idle(8);
    rst = 1'b0;
    idle(2);
    t_reset_state();
    t_mode_and_cmd();
    t_data_path();
    t_status();
    t_internal_reset();
    t_recovery_from_cmd();
    t_recovery_from_mode();
    t_reset_width();
    t_held_strobe();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule